// File: doc/BRIEF.md
# Embedded Core Program Download Port

This block is the host-facing download window of a small embedded microcontroller. A single 32-bit control word carries a mode byte, a data byte and a byte address. The host uses it to place the core in reset, write a program image into the core's 8-bit program memory one byte per write, and read the image back for verification. Finally it records that the image is complete and verified, which releases the core from reset.

The host writes through a simple strobe interface: `wr_en` with `wdata`, and `rd_en` with the result on `rdata` one cycle later. The mode byte sits in bits 31:24 of the word, the data byte in bits 23:16, and the 14-bit byte address in bits 13:0. Bits 15:14 carry no address meaning.

In upload mode (mode byte 0x0F), every write stores a byte and moves an internal read pointer to that address. Every read returns the byte at the pointer and then advances the pointer. A host can therefore write a byte, read the word back, and compare it with what it wrote. It can also rewind and stream the whole image back. Mode byte 0x03 closes an upload and records the image size. Mode byte 0x13 marks the image verified and is the only value that lets the core run. The program memory itself sits outside the block, on a single-address port with an asynchronous read.

Top module: `dlport_top`

## Requirements
- R1: After synchronous reset the mode byte is 0x00, `core_rst` is 1, `upload_mode`, `load_done` and `load_verified` are 0, `rdata` is 0 and the read pointer is 0.
- R2: A write whose bits 31:24 equal 0x0F enters upload mode from the next cycle: `upload_mode`=1, `core_rst`=1, and `load_done` and `load_verified` are cleared.
- R3: A write whose bits 31:24 equal 0x0F drives, in the same cycle, `mem_we`=1, `mem_addr`=wdata[13:0] and `mem_wdata`=wdata[23:16]; bits 15:14 never reach the address.
- R4: An upload write loads the read pointer with wdata[13:0] and retains wdata[15:14]. A following read returns exactly the word that was written, provided the memory holds that byte.
- R5: A read while in upload mode (and no write in that cycle) returns, on `rdata` in the next cycle, the mode byte in [31:24], the memory byte at the pointer in [23:16], the retained bits in [15:14] and the pointer in [13:0]. The pointer then increments by one. Between writes, `mem_addr` shows the pointer.
- R6: The read pointer is 14 bits wide and wraps from 0x3FFF to 0x0000.
- R7: A write with bits 31:24 equal 0x03 leaves upload mode, sets `load_done`, clears `load_verified`, stores wdata[15:0] as the image size and keeps `core_rst` at 1.
- R8: A write with bits 31:24 equal 0x13 stores wdata[15:0] as the size, sets `load_done` and `load_verified`, and drops `core_rst` to 0 from the next cycle.
- R9: For every mode byte other than 0x13, including unknown values, `core_rst` is 1. An unknown mode byte leaves the flags and the size unchanged.
- R10: Outside upload mode a write never asserts `mem_we`. A read returns {mode byte, 0x00, size[15:0]} and does not move the pointer.
- R11: When `wr_en` and `rd_en` are both high in one cycle, the write takes effect and the read is ignored: `rdata` keeps its value and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Word to write (mode, data byte, spare bits, address) |
| rdata | output | 32 | Registered read result, valid the cycle after `rd_en` |
| mem_we | output | 1 | Program memory write enable |
| mem_addr | output | 14 | Program memory byte address |
| mem_wdata | output | 8 | Program memory write byte |
| mem_rdata | input | 8 | Program memory read byte (asynchronous, at `mem_addr`) |
| core_rst | output | 1 | Hold the embedded core in reset |
| upload_mode | output | 1 | Upload mode is active |
| load_done | output | 1 | Image load closed |
| load_verified | output | 1 | Image marked verified |

## Verification
The bench targets the pointer at its ends. It checks the wrap from 0x3FFF back to zero, which a pointer one bit too wide or with saturating logic would miss, and a rewind by write, after which a design that ignored the write's address would stream bytes from the wrong place. It drives writes whose spare bits 15:14 are set, so that a design leaking them into the address would store at a mirror location. It also issues a write and a read in the same cycle, where a design giving the read priority would advance the pointer or change `rdata`. Finally it walks the mode byte through unknown values and back into upload mode after verification: a decoder that released reset on anything but 0x13, or kept it released, shows up on `core_rst`.

// File: rtl/dlport_pkg.sv
package dlport_pkg;

    localparam int WORD_W = 32;
    localparam int MODE_W = 8;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = 2;
    localparam int ADDR_W = 14;
    localparam int SIZE_W = PAD_W + ADDR_W;

    localparam logic [MODE_W-1:0] MODE_UPLOAD   = 8'h0F;
    localparam logic [MODE_W-1:0] MODE_LOADED   = 8'h03;
    localparam logic [MODE_W-1:0] MODE_VERIFIED = 8'h13;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [BYTE_W-1:0] data;
        logic [PAD_W-1:0]  pad;
        logic [ADDR_W-1:0] addr;
    } dl_word_t;

    typedef enum logic [1:0] {
        KIND_OTHER,
        KIND_UPLOAD,
        KIND_LOADED,
        KIND_VERIFIED
    } dl_kind_e;

    function automatic dl_kind_e classify(input logic [MODE_W-1:0] m);
        case (m)
            MODE_UPLOAD:   return KIND_UPLOAD;
            MODE_LOADED:   return KIND_LOADED;
            MODE_VERIFIED: return KIND_VERIFIED;
            default:       return KIND_OTHER;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
        return p + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/dlport_mode_ctrl.sv
module dlport_mode_ctrl
    import dlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [SIZE_W-1:0] wr_low,
    output logic [MODE_W-1:0] mode_q,
    output logic [PAD_W-1:0]  pad_q,
    output logic [SIZE_W-1:0] size_q,
    output logic              done_q,
    output logic              verified_q,
    output logic              in_upload,
    output logic              hold_core
);

    dl_kind_e wr_kind;
    dl_kind_e cur_kind;

    always_comb begin
        wr_kind  = classify(wr_mode);
        cur_kind = classify(mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            pad_q      <= '0;
            size_q     <= '0;
            done_q     <= 1'b0;
            verified_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wr_mode;
            case (wr_kind)
                KIND_UPLOAD: begin
                    pad_q      <= wr_low[SIZE_W-1 -: PAD_W];
                    done_q     <= 1'b0;
                    verified_q <= 1'b0;
                end
                KIND_LOADED: begin
                    size_q     <= wr_low;
                    done_q     <= 1'b1;
                    verified_q <= 1'b0;
                end
                KIND_VERIFIED: begin
                    size_q     <= wr_low;
                    done_q     <= 1'b1;
                    verified_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        in_upload = (cur_kind == KIND_UPLOAD);
        hold_core = (cur_kind != KIND_VERIFIED);
    end

endmodule

// File: rtl/dlport_rd_ptr.sv
module dlport_rd_ptr
    import dlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (advance) begin
            ptr_q <= ptr_step(ptr_q);
        end
    end

endmodule

// File: rtl/dlport_rdback.sv
module dlport_rdback
    import dlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              in_upload,
    input  logic [MODE_W-1:0] mode_q,
    input  logic [BYTE_W-1:0] mem_byte,
    input  logic [PAD_W-1:0]  pad_q,
    input  logic [ADDR_W-1:0] ptr_q,
    input  logic [SIZE_W-1:0] size_q,
    output logic [WORD_W-1:0] rdata_q
);

    dl_word_t nxt;

    always_comb begin
        nxt.mode = mode_q;
        if (in_upload) begin
            nxt.data = mem_byte;
            nxt.pad  = pad_q;
            nxt.addr = ptr_q;
        end else begin
            nxt.data = '0;
            {nxt.pad, nxt.addr} = size_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (fire) begin
            rdata_q <= nxt;
        end
    end

endmodule

// File: rtl/dlport_top.sv
module dlport_top
    import dlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              core_rst,
    output logic              upload_mode,
    output logic              load_done,
    output logic              load_verified
);

    dl_word_t          wword;
    logic [MODE_W-1:0] mode_q;
    logic [PAD_W-1:0]  pad_q;
    logic [SIZE_W-1:0] size_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              in_upload;
    logic              up_write;
    logic              rd_fire;

    always_comb begin
        wword    = dl_word_t'(wdata);
        up_write = wr_en && (classify(wword.mode) == KIND_UPLOAD);
        rd_fire  = rd_en && !wr_en;
    end

    dlport_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_mode    (wword.mode),
        .wr_low     ({wword.pad, wword.addr}),
        .mode_q     (mode_q),
        .pad_q      (pad_q),
        .size_q     (size_q),
        .done_q     (load_done),
        .verified_q (load_verified),
        .in_upload  (in_upload),
        .hold_core  (core_rst)
    );

    dlport_rd_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (up_write),
        .load_addr (wword.addr),
        .advance   (rd_fire && in_upload),
        .ptr_q     (ptr_q)
    );

    dlport_rdback u_rd (
        .clk       (clk),
        .rst       (rst),
        .fire      (rd_fire),
        .in_upload (in_upload),
        .mode_q    (mode_q),
        .mem_byte  (mem_rdata),
        .pad_q     (pad_q),
        .ptr_q     (ptr_q),
        .size_q    (size_q),
        .rdata_q   (rdata)
    );

    always_comb begin
        mem_we      = up_write;
        mem_addr    = up_write ? wword.addr : ptr_q;
        mem_wdata   = wword.data;
        upload_mode = in_upload;
    end

endmodule

// File: rtl/dlport_chk.sv
module dlport_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        mem_we,
    input logic [13:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic [7:0]  mem_rdata,
    input logic        core_rst,
    input logic        upload_mode,
    input logic        load_done,
    input logic        load_verified
);

    // R2
    enter_upload_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[31:24] == 8'h0F) |=> (upload_mode && core_rst && !load_done && !load_verified));

    // R3
    store_port_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (wr_en && mem_addr == wdata[13:0] && mem_wdata == wdata[23:16]));

    // R5
    upload_read_chk: assert property (@(posedge clk) disable iff (rst)
        (upload_mode && rd_en && !wr_en) |=> (rdata[31:24] == 8'h0F && rdata[23:16] == $past(mem_rdata)));

    // R7
    close_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[31:24] == 8'h03) |=> (load_done && !load_verified && !upload_mode && core_rst));

    // R8
    release_core_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[31:24] == 8'h13) |=> (!core_rst && load_verified && rdata == $past(rdata)));

    // R9
    reset_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !core_rst |-> (load_verified && load_done && !upload_mode));

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!upload_mode && rd_en && !wr_en) |=> (rdata[23:16] == 8'h00 && !mem_we));

    // R11
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(rdata));

endmodule

bind dlport_top dlport_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .wdata         (wdata),
    .rdata         (rdata),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .core_rst      (core_rst),
    .upload_mode   (upload_mode),
    .load_done     (load_done),
    .load_verified (load_verified)
);

// File: tb/tb_dlport_top.sv
`timescale 1ns/1ps
module tb_dlport_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        core_rst;
    logic        upload_mode;
    logic        load_done;
    logic        load_verified;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dlport_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .core_rst(core_rst), .upload_mode(upload_mode),
        .load_done(load_done), .load_verified(load_verified)
    );

    // external program memory
    logic [7:0] pmem [int];
    int mem_gen = 0;
    always @(posedge clk) if (mem_we) begin
        pmem[int'(mem_addr)] = mem_wdata;
        mem_gen++;
    end
    always @(mem_addr, mem_gen)
        mem_rdata = pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 8'h00;

    // behavioural reference model
    logic [7:0]  ref_mem [int];
    logic [7:0]  m_mode = 0;
    int          m_ptr = 0;
    logic [1:0]  m_pad = 0;
    logic [15:0] m_size = 0;
    bit          m_done = 0, m_ver = 0;
    logic [31:0] m_rdata = 0;

    function automatic logic [7:0] ref_byte(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "rdata", rdata, m_rdata);
        check(tag, "core_rst", 32'(core_rst), 32'(m_mode != 8'h13));
        check(tag, "upload_mode", 32'(upload_mode), 32'(m_mode == 8'h0F));
        check(tag, "load_done", 32'(load_done), 32'(m_done));
        check(tag, "load_verified", 32'(load_verified), 32'(m_ver));
    endtask

    task automatic step(bit wr, bit rd, logic [31:0] w, string tag);
        bit up;
        @(negedge clk);
        wr_en = wr; rd_en = rd; wdata = w;
        #1;
        up = wr && (w[31:24] == 8'h0F);
        check(tag, "mem_we", 32'(mem_we), 32'(up));
        if (up) begin
            check(tag, "mem_addr(write)", 32'(mem_addr), 32'(w[13:0]));
            check(tag, "mem_wdata", 32'(mem_wdata), 32'(w[23:16]));
        end else begin
            check(tag, "mem_addr(ptr)", 32'(mem_addr), 32'(m_ptr));
        end
        @(posedge clk);
        if (wr) begin
            m_mode = w[31:24];
            if (m_mode == 8'h0F) begin
                ref_mem[int'(w[13:0])] = w[23:16];
                m_ptr = int'(w[13:0]);
                m_pad = w[15:14];
                m_done = 0; m_ver = 0;
            end else if (m_mode == 8'h03) begin
                m_size = w[15:0]; m_done = 1; m_ver = 0;
            end else if (m_mode == 8'h13) begin
                m_size = w[15:0]; m_done = 1; m_ver = 1;
            end
        end else if (rd) begin
            if (m_mode == 8'h0F) begin
                m_rdata = {m_mode, ref_byte(m_ptr), m_pad, 14'(m_ptr)};
                m_ptr = (m_ptr + 1) % 16384;
            end else begin
                m_rdata = {m_mode, 8'h00, m_size};
            end
        end
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        compare_all("R1");
        check("R1", "mem_addr", 32'(mem_addr), 32'h0);

        // R2 enter upload
        step(1, 0, 32'h0F00_0000, "R2");

        // R3 / R4 byte writes with immediate readback
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            w = {8'h0F, 8'(8'hA0 + i * 7), 2'b00, 14'(i)};
            step(1, 0, w, "R3");
            step(0, 1, 32'h0, "R4");
            check("R4", "readback equals written", rdata, w);
        end

        // R3 spare bits not part of address
        step(1, 0, 32'h0FAB_C005, "R3");
        step(0, 1, 32'h0, "R4");
        check("R4", "spare-bit readback", rdata, 32'h0FAB_C005);

        // R5 rewind and stream
        step(1, 0, 32'h0FA0_0000, "R5");
        for (int i = 0; i < 7; i++) step(0, 1, 32'h0, "R5");
        check("R5", "streamed addr 5 byte", 32'(pmem[5]), 32'h00AB);

        // R6 wrap
        step(1, 0, 32'h0F77_3FFF, "R6");
        step(0, 1, 32'h0, "R6");
        step(0, 1, 32'h0, "R6");
        check("R6", "wrapped addr field", 32'(rdata[13:0]), 32'h0);

        // R11 simultaneous write and read
        step(1, 1, 32'h0F5A_0010, "R11");
        step(0, 1, 32'h0, "R11");
        check("R11", "pointer loaded not advanced", 32'(rdata[13:0]), 32'h10);

        // R7 close load
        step(1, 0, 32'h0300_0011, "R7");
        step(0, 1, 32'h0, "R10");
        step(0, 1, 32'h0, "R10");
        step(1, 0, 32'h03AA_0011, "R10");
        step(0, 1, 32'h0, "R10");

        // R8 verified
        step(1, 0, 32'h1300_0011, "R8");
        step(0, 1, 32'h0, "R8");

        // R9 other modes keep reset asserted
        step(1, 0, 32'h5500_0000, "R9");
        step(0, 1, 32'h0, "R9");
        step(1, 0, 32'h1300_0020, "R9");
        step(1, 0, 32'h0F00_0003, "R9");
        step(0, 1, 32'h0, "R9");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule